// File: doc/BRIEF.md
# PSRAM Sleep and Power-State Manager

This block is the device-side controller that decides which power state a pseudo-static RAM model is in. After power is applied it holds the memory in an initialization state for a fixed number of microsecond ticks. It then reports ready. From the ready state, the active-low sleep pin can drop the device into a retention sleep, where refresh continues but accesses are refused, or into a deep power-down, where refresh stops and the contents are lost. Leaving deep power-down repeats the whole initialization delay.

The sleep pin also serves as the gate for loading the configuration register. A write cycle that starts within a short window after the pin falls copies the address bus into the register. The register can also be loaded by an in-band sequence of four accesses to the all-ones address: two reads, then two writes. Once that sequence has loaded the register, the sleep pin can no longer start retention sleep. This override lasts until the next reset.

The host side supplies a tick pulse once per microsecond, the bus controls and the address and data buses. It reads back the mode, a ready flag, an access-block flag, a refresh indication and the register contents. All inputs are taken to be synchronous to `clk`.

Top module: `psram_pwr_mgr`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `mode` is 0 (INIT), `ready` is 0, `access_block` is 1, `refresh_en` is 1 and `cfg` is 0x0070. The mode encoding is 0 INIT, 1 ACTIVE, 2 sleep with retention (PAR), 3 deep power-down (DPD).
- R2: `mode` stays INIT until INIT_TICKS tick pulses have been counted. It then becomes ACTIVE, with `ready` at 1.
- R3: In ACTIVE, if `sleep_n` stays low for SLEEP_TICKS tick pulses, the mode becomes PAR when `cfg[4]` is 1 and DPD when `cfg[4]` is 0. A shorter low pulse leaves the mode at ACTIVE.
- R4: In PAR, a high `sleep_n` returns the mode to ACTIVE on the next clock.
- R5: In DPD, a high `sleep_n` moves the mode to INIT on the next clock. ACTIVE is reached again only after a fresh INIT_TICKS count.
- R6: `access_block` is 1 whenever the mode is not ACTIVE or `sleep_n` is low. Bus writes made in PAR or DPD leave `cfg` and `mode` unchanged.
- R7: In ACTIVE, a write (`ce_n` and `we_n` both low) that begins within LOAD_WIN_CYC clocks of the `sleep_n` fall loads `cfg` with the address held during the write. The load happens when `ce_n` or `we_n` rises, whichever rises first. A write that begins later loads nothing.
- R8: `refresh_en` is 0 in DPD. In PAR it is 0 only when `cfg[2:0]` is 100; any other code gives 1. In INIT and ACTIVE it is 1.
- R9: In ACTIVE with `sleep_n` high, four consecutive `ce_n`-low accesses to the all-ones address, in the order read, read, write, write, load `cfg` with `wdata` (zero-extended) from the last write. An access to any other address restarts the sequence.
- R10: After a load by the R9 sequence, a long low `sleep_n` with `cfg[4]` at 1 leaves the mode at ACTIVE. A reset clears this override.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (power-up) |
| tick_us | input | 1 | One-cycle pulse per microsecond |
| sleep_n | input | 1 | Active-low sleep pin |
| ce_n | input | 1 | Active-low chip enable |
| we_n | input | 1 | Active-low write enable |
| addr | input | ADDR_W | Address bus |
| wdata | input | DATA_W | Write data bus, used by the in-band register load |
| ready | output | 1 | Device is in ACTIVE |
| access_block | output | 1 | Array reads and writes must be refused |
| mode | output | 2 | Power state: 0 INIT, 1 ACTIVE, 2 PAR, 3 DPD |
| refresh_en | output | 1 | Self-refresh is running |
| cfg | output | ADDR_W | Configuration register |

## Verification
The bench builds the block with INIT_TICKS=6, SLEEP_TICKS=4 and LOAD_WIN_CYC=4, and drives one tick every four clocks. At these values a complete initialization, a retention sleep, a deep power-down with its re-initialization, and the cases just inside and just outside the load window each take a few dozen cycles. That lets a single run cover every refresh code, both sleep selections, the override and its clearing by reset. The short sleep limit also puts a late-window write below the sleep threshold, so that case can be told apart from a sleep entry.

// File: rtl/psram_pm_pkg.sv
// Shared types and constants for the PSRAM power-state manager.
package psram_pm_pkg;

    // Power state encoding seen at the mode port.
    typedef enum logic [1:0] {
        PM_INIT   = 2'd0,
        PM_ACTIVE = 2'd1,
        PM_PAR    = 2'd2,
        PM_DPD    = 2'd3
    } pm_mode_e;

    // Register bit that picks retention sleep (1) or deep power-down (0).
    localparam int          SLEEP_SEL_BIT = 4;
    // Refresh-coverage code that stops refresh in retention sleep.
    localparam logic [2:0]  REFRESH_NONE  = 3'b100;
    // Register value after power-up.
    localparam int          CFG_RESET     = 'h70;

endpackage

// File: rtl/pm_tick_timer.sv
// Saturating counter of tick pulses.
// Assumes: tick is a one-cycle pulse; LIMIT >= 1.
// The count clears while clr is high and advances on tick while run is high.
// hit is high once LIMIT ticks have been counted and stays high until clr.
module pm_tick_timer #(
    parameter int LIMIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  logic tick,
    output logic hit
);
    localparam int            CW  = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    // Count ticks, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (run && tick && (cnt_q != LIM)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign hit = (cnt_q == LIM);
endmodule

// File: rtl/pm_cfg_ctl.sv
// Configuration register with its two load paths.
// The pin path: a write that starts within WIN_CYC clocks of the sleep-pin fall
// loads the address bus on the first rise of ce_n or we_n.
// The in-band path: read, read, write, write at the all-ones address with the
// pin high loads wdata, and sets a sticky override flag.
// Assumes: all inputs are synchronous to clk; DATA_W <= ADDR_W.
module pm_cfg_ctl #(
    parameter int ADDR_W  = 21,
    parameter int DATA_W  = 16,
    parameter int WIN_CYC = 62
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              sleep_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [ADDR_W-1:0] cfg,
    output logic              sw_ovr
);
    import psram_pm_pkg::*;

    localparam int                WW       = $clog2(WIN_CYC + 1);
    localparam logic [WW-1:0]     WLIM     = WW'(WIN_CYC);
    localparam logic [ADDR_W-1:0] ADDR_TOP = '1;

    logic [WW-1:0]     win_q;
    logic              armed_q;
    logic [ADDR_W-1:0] addr_q;
    logic              ce_q;
    logic              op_wr_q;
    logic              op_top_q;
    logic [DATA_W-1:0] wd_q;
    logic [1:0]        seq_q;
    logic [ADDR_W-1:0] cfg_q;
    logic              ovr_q;

    logic win_open, zz_start, zz_end, op_end, sw_en, sw_load, at_top;

    assign at_top   = (addr == ADDR_TOP);
    assign win_open = !sleep_n && (win_q != WLIM);
    assign zz_start = active && win_open && !ce_n && !we_n;
    assign zz_end   = armed_q && (ce_n || we_n);
    assign op_end   = !ce_q && ce_n;
    assign sw_en    = active && sleep_n;
    assign sw_load  = op_end && sw_en && op_top_q && op_wr_q && (seq_q == 2'd3);

    // Count clocks since the sleep-pin fall, saturating at the window length.
    always_ff @(posedge clk) begin
        if (!rst_n || sleep_n) begin
            win_q <= '0;
        end else if (win_q != WLIM) begin
            win_q <= win_q + 1'b1;
        end
    end

    // Arm a pin-path load when a write begins inside the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (zz_end || sleep_n) begin
            armed_q <= 1'b0;
        end else if (zz_start) begin
            armed_q <= 1'b1;
        end
    end

    // Hold the address seen during the last cycle with both strobes low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (!ce_n && !we_n) begin
            addr_q <= addr;
        end
    end

    // Track the kind, address and write data of the current chip-enable access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_q     <= 1'b1;
            op_wr_q  <= 1'b0;
            op_top_q <= 1'b0;
            wd_q     <= '0;
        end else begin
            ce_q <= ce_n;
            if (!ce_n) begin
                if (ce_q) begin
                    op_wr_q  <= !we_n;
                    op_top_q <= at_top;
                end else begin
                    op_wr_q  <= op_wr_q || !we_n;
                    op_top_q <= op_top_q && at_top;
                end
                if (!we_n) begin
                    wd_q <= wdata;
                end
            end
        end
    end

    // Step through read, read, write, write; a read restarts at step one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= 2'd0;
        end else if (op_end) begin
            if (!sw_en || !op_top_q) begin
                seq_q <= 2'd0;
            end else if (op_wr_q == seq_q[1]) begin
                seq_q <= seq_q + 2'd1;
            end else begin
                seq_q <= op_wr_q ? 2'd0 : 2'd1;
            end
        end
    end

    // Register contents and the sticky override left by an in-band load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= ADDR_W'(CFG_RESET);
            ovr_q <= 1'b0;
        end else if (zz_end) begin
            cfg_q <= addr_q;
        end else if (sw_load) begin
            cfg_q <= ADDR_W'(wd_q);
            ovr_q <= 1'b1;
        end
    end

    assign cfg    = cfg_q;
    assign sw_ovr = ovr_q;
endmodule

// File: rtl/psram_pwr_mgr.sv
// Power-state manager for a pseudo-static RAM model.
// Sequences INIT -> ACTIVE, and enters retention sleep or deep power-down from
// a long low on sleep_n. Leaving deep power-down repeats the INIT delay.
// Assumes: tick_us pulses once per microsecond for one clock; inputs are
// synchronous to clk; rst_n models power-up.
module psram_pwr_mgr #(
    parameter int ADDR_W       = 21,
    parameter int DATA_W       = 16,
    parameter int INIT_TICKS   = 150,
    parameter int SLEEP_TICKS  = 10,
    parameter int LOAD_WIN_CYC = 62
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_us,
    input  logic              sleep_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ready,
    output logic              access_block,
    output logic [1:0]        mode,
    output logic              refresh_en,
    output logic [ADDR_W-1:0] cfg
);
    import psram_pm_pkg::*;

    pm_mode_e mode_q;
    logic     init_hit, sleep_hit, sw_ovr;

    pm_tick_timer #(.LIMIT(INIT_TICKS)) init_tmr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (mode_q != PM_INIT),
        .run   (mode_q == PM_INIT),
        .tick  (tick_us),
        .hit   (init_hit)
    );

    pm_tick_timer #(.LIMIT(SLEEP_TICKS)) sleep_tmr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sleep_n || (mode_q != PM_ACTIVE)),
        .run   (!sleep_n && (mode_q == PM_ACTIVE)),
        .tick  (tick_us),
        .hit   (sleep_hit)
    );

    pm_cfg_ctl #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .WIN_CYC (LOAD_WIN_CYC)
    ) cfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (mode_q == PM_ACTIVE),
        .sleep_n (sleep_n),
        .ce_n    (ce_n),
        .we_n    (we_n),
        .addr    (addr),
        .wdata   (wdata),
        .cfg     (cfg),
        .sw_ovr  (sw_ovr)
    );

    // Power-state transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= PM_INIT;
        end else begin
            unique case (mode_q)
                PM_INIT:   if (init_hit) mode_q <= PM_ACTIVE;
                PM_ACTIVE: if (!sleep_n && sleep_hit) begin
                               if (!cfg[SLEEP_SEL_BIT]) mode_q <= PM_DPD;
                               else if (!sw_ovr)        mode_q <= PM_PAR;
                           end
                PM_PAR:    if (sleep_n) mode_q <= PM_ACTIVE;
                PM_DPD:    if (sleep_n) mode_q <= PM_INIT;
                default:   mode_q <= PM_INIT;
            endcase
        end
    end

    // Refresh indication per state and refresh-coverage code.
    always_comb begin
        unique case (mode_q)
            PM_DPD:  refresh_en = 1'b0;
            PM_PAR:  refresh_en = (cfg[2:0] != REFRESH_NONE);
            default: refresh_en = 1'b1;
        endcase
    end

    assign mode         = mode_q;
    assign ready        = (mode_q == PM_ACTIVE);
    assign access_block = !ready || !sleep_n;
endmodule

// File: rtl/psram_pm_chk.sv
// Temporal checks for the power-state manager, bound to the top module.
module psram_pm_chk #(
    parameter int ADDR_W = 21
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sleep_n,
    input logic [1:0]        mode,
    input logic              ready,
    input logic [ADDR_W-1:0] cfg,
    input logic              sw_ovr
);
    // R4
    par_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && sleep_n) |=> (mode == 2'd1));

    // R5
    dpd_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3 && sleep_n) |=> (mode == 2'd0));

    // R3
    dpd_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3 && $past(mode) == 2'd1) |-> !$past(cfg[4]));

    // R6
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 || mode == 2'd3) |=> $stable(cfg));

    // R10
    ovr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && sw_ovr && cfg[4]) |=> (mode != 2'd2));

    // R2
    ready_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> ($past(mode) == 2'd0 || $past(mode) == 2'd2));
endmodule

bind psram_pwr_mgr psram_pm_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .sleep_n (sleep_n),
    .mode    (mode),
    .ready   (ready),
    .cfg     (cfg),
    .sw_ovr  (sw_ovr)
);

// File: tb/psram_pwr_mgr_tb_top.sv
`timescale 1ns/1ps
module psram_pwr_mgr_tb_top;
    localparam int AW     = 21;
    localparam int DW     = 16;
    localparam int INIT_T = 6;
    localparam int SLP_T  = 4;
    localparam int WIN    = 4;
    localparam logic [AW-1:0] TOP_A = '1;

    // Vector table: pin-path load address, expected mode and refresh after long sleep.
    localparam logic [AW-1:0] V_ADDR [0:4] = '{21'h10, 21'h14, 21'h15, 21'h70, 21'h00};
    localparam logic [1:0]    V_MODE [0:4] = '{2'd2, 2'd2, 2'd2, 2'd2, 2'd3};
    localparam logic          V_REF  [0:4] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0};

    logic          clk = 1'b0, rst_n = 1'b0, tick_us = 1'b0;
    logic          sleep_n = 1'b1, ce_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          ready, access_block, refresh_en;
    logic [1:0]    mode;
    logic [AW-1:0] cfg;
    logic [1:0]    tph = '0;
    int            checks = 0, errors = 0;
    bit            done = 1'b0;

    psram_pwr_mgr #(
        .ADDR_W(AW), .DATA_W(DW), .INIT_TICKS(INIT_T),
        .SLEEP_TICKS(SLP_T), .LOAD_WIN_CYC(WIN)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .sleep_n(sleep_n),
        .ce_n(ce_n), .we_n(we_n), .addr(addr), .wdata(wdata),
        .ready(ready), .access_block(access_block), .mode(mode),
        .refresh_en(refresh_en), .cfg(cfg)
    );

    always #4 clk = ~clk;

    // One tick every four clocks, changed away from the active edge.
    always @(negedge clk) begin
        tph     <= tph + 2'd1;
        tick_us <= (tph == 2'd3);
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        addr = a; wdata = d; ce_n = 1'b0; we_n = !wr;
        cyc(2);
        ce_n = 1'b1; we_n = 1'b1;
        cyc(2);
    endtask

    task automatic zz_load(input logic [AW-1:0] a, input bit late, input bit ce_first);
        sleep_n = 1'b0;
        cyc(late ? 5 : 1);
        addr = a; ce_n = 1'b0; we_n = 1'b0;
        cyc(2);
        if (ce_first) ce_n = 1'b1; else we_n = 1'b1;
        cyc(1);
        ce_n = 1'b1; we_n = 1'b1;
        cyc(2);
        sleep_n = 1'b1;
        cyc(2);
    endtask

    initial begin
        cyc(3);
        chk("R1 mode", 32'(mode), 32'd0);
        chk("R1 ready", 32'(ready), 32'd0);
        chk("R1 access_block", 32'(access_block), 32'd1);
        chk("R1 refresh_en", 32'(refresh_en), 32'd1);
        chk("R1 cfg", 32'(cfg), 32'h70);
        rst_n = 1'b1;
        cyc((INIT_T - 2) * 4);
        chk("R2 still init", 32'(mode), 32'd0);
        cyc(16);
        chk("R2 active", 32'(mode), 32'd1);
        chk("R2 ready", 32'(ready), 32'd1);
        chk("R6 no block", 32'(access_block), 32'd0);

        // Pin low blocks access; a late write does not load; a short low keeps ACTIVE.
        sleep_n = 1'b0;
        cyc(2);
        chk("R6 block on pin low", 32'(access_block), 32'd1);
        sleep_n = 1'b1;
        cyc(2);
        zz_load(21'h00055, 1'b1, 1'b0);
        chk("R7 late write ignored", 32'(cfg), 32'h70);
        chk("R3 short low stays active", 32'(mode), 32'd1);

        // Walk the vector table.
        for (int i = 0; i < 5; i++) begin
            zz_load(V_ADDR[i], 1'b0, (i == 2));
            chk("R7 pin load", 32'(cfg), 32'(V_ADDR[i]));
            sleep_n = 1'b0;
            cyc(SLP_T * 4 + 8);
            chk("R3 sleep mode", 32'(mode), 32'(V_MODE[i]));
            chk("R8 refresh", 32'(refresh_en), 32'(V_REF[i]));
            chk("R6 block asleep", 32'(access_block), 32'd1);
            bus_op(1'b1, 21'h000AA, 16'h00AA);
            chk("R6 cfg held asleep", 32'(cfg), 32'(V_ADDR[i]));
            chk("R6 mode held asleep", 32'(mode), 32'(V_MODE[i]));
            sleep_n = 1'b1;
            cyc(1);
            if (V_MODE[i] == 2'd2) begin
                chk("R4 retention exit", 32'(mode), 32'd1);
            end else begin
                chk("R5 deep exit to init", 32'(mode), 32'd0);
                cyc((INIT_T - 2) * 4);
                chk("R5 still init", 32'(mode), 32'd0);
                cyc(16);
                chk("R5 active again", 32'(mode), 32'd1);
            end
            cyc(2);
        end

        // In-band load sequence.
        bus_op(1'b0, TOP_A, 16'h0);
        bus_op(1'b0, TOP_A, 16'h0);
        bus_op(1'b1, TOP_A, 16'h0090);
        bus_op(1'b1, TOP_A, 16'h0090);
        cyc(1);
        chk("R9 in-band load", 32'(cfg), 32'h90);
        sleep_n = 1'b0;
        cyc(SLP_T * 4 + 8);
        chk("R10 override keeps active", 32'(mode), 32'd1);
        sleep_n = 1'b1;
        cyc(2);

        // Broken sequence does not load.
        bus_op(1'b0, TOP_A, 16'h0);
        bus_op(1'b0, 21'h12345, 16'h0);
        bus_op(1'b1, TOP_A, 16'h0011);
        bus_op(1'b1, TOP_A, 16'h0011);
        cyc(1);
        chk("R9 broken sequence", 32'(cfg), 32'h90);

        // Reset clears the override.
        rst_n = 1'b0;
        cyc(2);
        chk("R10 cfg after reset", 32'(cfg), 32'h70);
        rst_n = 1'b1;
        cyc(INIT_T * 4 + 8);
        sleep_n = 1'b0;
        cyc(SLP_T * 4 + 8);
        chk("R10 sleep after reset", 32'(mode), 32'd2);
        sleep_n = 1'b1;
        cyc(2);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule